// File: doc/BRIEF.md
# Per-CPU Interrupt Claim and Completion Interface

This block is the interrupt interface that sits beside a single CPU. Level-style pending lines arrive from trigger logic that lives elsewhere, one line per interrupt number. Software works only with interrupt numbers, never with bitmasks. Writing a number to one strobe register enables that line, and writing it to another strobe register masks it again. The CPU takes an interrupt by reading a ready register, and it hands the interrupt back by writing the same number to a completion register. A completion also sends a one-cycle clear pulse back to the trigger logic for that line.

A set of flags per number tracks enable and in-service. A read of the ready register returns the lowest-numbered line that is pending, enabled and not yet in service, and marks it in service. A small state machine drives the request output to the core. It has three states. IRQ_OFF holds while the global enable bit is clear. IRQ_QUIET holds while the block is enabled and no candidate exists. IRQ_RAISED holds while the block is enabled and a candidate exists. Every state moves to IRQ_OFF when the enable bit is cleared. IRQ_OFF moves to IRQ_QUIET or to IRQ_RAISED when the bit is set, depending on whether a candidate exists. IRQ_QUIET and IRQ_RAISED swap as candidates appear and disappear.

A send register produces a one-cycle pulse vector toward the other CPUs, for inter-processor signalling.

Top module: `cpu_claim_intf`

## Requirements
- R1: After reset, irq_o, clr_o, ipi_o and ipi_id_o are all zero, and every enable flag, every in-service flag and the global enable bit are clear.
- R2: Offset 0x00 is the control register, and its bit 0 is the global enable. A read of it returns that bit in bit 0, with zero in every other bit.
- R3: Writing an interrupt number to offset 0xA0 sets the enable flag of that number. Writing a number to offset 0xA4 clears the enable flag of that number.
- R4: A read of offset 0x6C returns the lowest number whose line is pending, enabled and not in service, and it sets the in-service flag of that number. The read works whether or not the global enable bit is set.
- R5: When no number qualifies, a read of offset 0x6C returns 0xFFFF_FFFF and changes no flag.
- R6: irq_o is a registered output. It is high in the cycle after a cycle in which the global enable bit is set and at least one qualifying number exists, and it is low otherwise.
- R7: Writing a number to offset 0xB4 clears the in-service flag of that number. It also raises only clr_o[number], for exactly the one cycle after the write.
- R8: A write to offset 0x60 drives ipi_o with write-data bits [8+NUM_CPUS-1:8] and ipi_id_o with bits [3:0] for the one cycle after the write. Both outputs are zero at every other time. Mask bits above NUM_CPUS are ignored.
- R9: A number written to offset 0xA0, 0xA4 or 0xB4 whose full 32-bit value is NUM_IDS or larger has no effect. It does not alias onto a lower number.
- R10: Every read returns its data with rsp_valid high in the cycle after the request. Reads of any offset other than 0x00 and 0x6C return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| pend_i | input | NUM_IDS | Pending level per interrupt number |
| irq_o | output | 1 | Interrupt request to the core |
| clr_o | output | NUM_IDS | One-cycle clear pulse per number, sent on completion |
| ipi_o | output | NUM_CPUS | One-cycle inter-processor pulse vector |
| ipi_id_o | output | 4 | Interrupt number carried with the send pulse |

## Verification
The bench builds the block with NUM_IDS = 40 and NUM_CPUS = 4. With 40 numbers, the ID field is six bits wide but not fully populated. Numbers 40 to 63, and values such as 0x103 whose low bits name a real line, then become reachable, so the no-aliasing rule can be tested. With four CPUs, the upper nibble of the send mask field is outside the target range, so writing ones there shows that those bits are dropped.

// File: rtl/cci_pkg.sv
package cci_pkg;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_SEND  = 8'h60;
    localparam logic [7:0] OFS_READY = 8'h6C;
    localparam logic [7:0] OFS_SETEN = 8'hA0;
    localparam logic [7:0] OFS_CLREN = 8'hA4;
    localparam logic [7:0] OFS_DONE  = 8'hB4;

    localparam logic [31:0] NO_ID = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        IRQ_OFF    = 2'd0,
        IRQ_QUIET  = 2'd1,
        IRQ_RAISED = 2'd2
    } irq_state_e;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_CTRL_WR  = 4'd1,
        OP_SEND     = 4'd2,
        OP_SETEN    = 4'd3,
        OP_CLREN    = 4'd4,
        OP_DONE     = 4'd5,
        OP_CLAIM    = 4'd6,
        OP_CTRL_RD  = 4'd7,
        OP_OTHER_RD = 4'd8,
        OP_OTHER_WR = 4'd9
    } bus_op_e;

endpackage

// File: rtl/cci_decode.sv
module cci_decode
    import cci_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    output bus_op_e    op
);

    always_comb begin
        op = OP_NONE;
        if (req_valid) begin
            if (req_write) begin
                case (req_addr)
                    OFS_CTRL:  op = OP_CTRL_WR;
                    OFS_SEND:  op = OP_SEND;
                    OFS_SETEN: op = OP_SETEN;
                    OFS_CLREN: op = OP_CLREN;
                    OFS_DONE:  op = OP_DONE;
                    default:   op = OP_OTHER_WR;
                endcase
            end else begin
                case (req_addr)
                    OFS_CTRL:  op = OP_CTRL_RD;
                    OFS_READY: op = OP_CLAIM;
                    default:   op = OP_OTHER_RD;
                endcase
            end
        end
    end

endmodule

// File: rtl/cci_lowest_pick.sv
module cci_lowest_pick #(
    parameter int N  = 256,
    parameter int IW = 8
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the last hit is the lowest number.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end

endmodule

// File: rtl/cci_id_bank.sv
module cci_id_bank
    import cci_pkg::*;
#(
    parameter int NUM_IDS = 256,
    parameter int ID_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_op_e            op,
    input  logic               id_ok,
    input  logic [ID_W-1:0]    id_idx,
    input  logic               claim_go,
    input  logic [ID_W-1:0]    claim_idx,
    output logic [NUM_IDS-1:0] en_q,
    output logic [NUM_IDS-1:0] insvc_q,
    output logic [NUM_IDS-1:0] clr_q
);

    logic set_hit, clr_hit, done_hit;

    assign set_hit  = (op == OP_SETEN) && id_ok;
    assign clr_hit  = (op == OP_CLREN) && id_ok;
    assign done_hit = (op == OP_DONE)  && id_ok;

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        logic me;
        logic mine_claim;

        assign me         = (id_idx == ID_W'(i));
        assign mine_claim = claim_go && (claim_idx == ID_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
            end else if (set_hit && me) begin
                en_q[i] <= 1'b1;
            end else if (clr_hit && me) begin
                en_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                insvc_q[i] <= 1'b0;
            end else if (mine_claim) begin
                insvc_q[i] <= 1'b1;
            end else if (done_hit && me) begin
                insvc_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clr_q[i] <= 1'b0;
            end else begin
                clr_q[i] <= done_hit && me;
            end
        end
    end

endmodule

// File: rtl/cci_irq_fsm.sv
module cci_irq_fsm
    import cci_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_en,
    input  logic any_cand,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_OFF: begin
                if (ctrl_en) begin
                    state_d = any_cand ? IRQ_RAISED : IRQ_QUIET;
                end
            end
            IRQ_QUIET: begin
                if (!ctrl_en) begin
                    state_d = IRQ_OFF;
                end else if (any_cand) begin
                    state_d = IRQ_RAISED;
                end
            end
            IRQ_RAISED: begin
                if (!ctrl_en) begin
                    state_d = IRQ_OFF;
                end else if (!any_cand) begin
                    state_d = IRQ_QUIET;
                end
            end
            default: state_d = IRQ_OFF;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/cpu_claim_intf.sv
module cpu_claim_intf
    import cci_pkg::*;
#(
    parameter int NUM_IDS  = 256,
    parameter int NUM_CPUS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [7:0]          req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    input  logic [NUM_IDS-1:0]  pend_i,
    output logic                irq_o,
    output logic [NUM_IDS-1:0]  clr_o,
    output logic [NUM_CPUS-1:0] ipi_o,
    output logic [3:0]          ipi_id_o
);

    localparam int ID_W      = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
    localparam int MASK_LSB  = 8;

    bus_op_e            op;
    logic               ctrl_q;
    logic [NUM_IDS-1:0] en_q;
    logic [NUM_IDS-1:0] insvc_q;
    logic [NUM_IDS-1:0] cand;
    logic               found;
    logic [ID_W-1:0]    pick_idx;
    logic               id_ok;
    logic               claim_go;

    cci_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .op        (op)
    );

    assign id_ok    = (req_wdata < 32'(NUM_IDS));
    assign cand     = pend_i & en_q & ~insvc_q;
    assign claim_go = (op == OP_CLAIM) && found;

    cci_lowest_pick #(
        .N  (NUM_IDS),
        .IW (ID_W)
    ) u_pick (
        .vec   (cand),
        .found (found),
        .idx   (pick_idx)
    );

    cci_id_bank #(
        .NUM_IDS (NUM_IDS),
        .ID_W    (ID_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .id_ok     (id_ok),
        .id_idx    (req_wdata[ID_W-1:0]),
        .claim_go  (claim_go),
        .claim_idx (pick_idx),
        .en_q      (en_q),
        .insvc_q   (insvc_q),
        .clr_q     (clr_o)
    );

    cci_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_q),
        .any_cand (found),
        .irq_o    (irq_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
        end else if (op == OP_CTRL_WR) begin
            ctrl_q <= req_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (op == OP_CLAIM) || (op == OP_CTRL_RD) || (op == OP_OTHER_RD);
            unique case (op)
                OP_CLAIM:   rsp_rdata <= found ? 32'(pick_idx) : NO_ID;
                OP_CTRL_RD: rsp_rdata <= {31'b0, ctrl_q};
                default:    rsp_rdata <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipi_o    <= '0;
            ipi_id_o <= '0;
        end else if (op == OP_SEND) begin
            ipi_o    <= req_wdata[MASK_LSB +: NUM_CPUS];
            ipi_id_o <= req_wdata[3:0];
        end else begin
            ipi_o    <= '0;
            ipi_id_o <= '0;
        end
    end

endmodule

// File: rtl/cci_checker.sv
module cci_checker
    import cci_pkg::*;
#(
    parameter int NUM_IDS  = 256,
    parameter int NUM_CPUS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [7:0]          req_addr,
    input logic                rsp_valid,
    input logic [31:0]         rsp_rdata,
    input logic [NUM_IDS-1:0]  pend_i,
    input logic                irq_o,
    input logic [NUM_IDS-1:0]  clr_o,
    input logic [NUM_CPUS-1:0] ipi_o,
    input logic                ctrl,
    input logic [NUM_IDS-1:0]  en,
    input logic [NUM_IDS-1:0]  insvc
);

    localparam int ID_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;

    logic [ID_W-1:0] rsp_id;
    assign rsp_id = rsp_rdata[ID_W-1:0];

    assert_irq_needs_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctrl));

    assert_irq_needs_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(pend_i & en & ~insvc)));

    assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    assert_clr_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> $past(req_valid && req_write && req_addr == OFS_DONE));

    assert_ipi_after_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ipi_o) |-> $past(req_valid && req_write && req_addr == OFS_SEND));

    assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_claim_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_rdata != NO_ID && $past(req_valid && !req_write && req_addr == OFS_READY))
        |-> insvc[rsp_id]);

endmodule

bind cpu_claim_intf cci_checker #(
    .NUM_IDS  (NUM_IDS),
    .NUM_CPUS (NUM_CPUS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .pend_i    (pend_i),
    .irq_o     (irq_o),
    .clr_o     (clr_o),
    .ipi_o     (ipi_o),
    .ctrl      (ctrl_q),
    .en        (en_q),
    .insvc     (insvc_q)
);

// File: tb/cpu_claim_intf_tb.sv
module cpu_claim_intf_tb;

    localparam int NI = 40;
    localparam int NC = 4;

    localparam logic [7:0]  A_CTRL  = 8'h00;
    localparam logic [7:0]  A_SEND  = 8'h60;
    localparam logic [7:0]  A_READY = 8'h6C;
    localparam logic [7:0]  A_SETEN = 8'hA0;
    localparam logic [7:0]  A_CLREN = 8'hA4;
    localparam logic [7:0]  A_DONE  = 8'hB4;
    localparam logic [31:0] NONE    = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write;
    logic [7:0]    req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NI-1:0] pend_i;
    logic          irq_o;
    logic [NI-1:0] clr_o;
    logic [NC-1:0] ipi_o;
    logic [3:0]    ipi_id_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cpu_claim_intf #(.NUM_IDS(NI), .NUM_CPUS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pend_i(pend_i), .irq_o(irq_o), .clr_o(clr_o),
        .ipi_o(ipi_o), .ipi_id_o(ipi_id_o)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Scoreboard monitor: each returned read is compared with the queued value.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected response", 64'(rsp_rdata), 64'hDEAD);
            end else begin
                chk(tag_q.pop_front(), 64'(rsp_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; pend_i = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq", 64'(irq_o), 64'd0);
        chk("R1 clr", 64'(clr_o), 64'd0);
        chk("R1 ipi", 64'(ipi_o), 64'd0);
        chk("R1 ipi_id", 64'(ipi_id_o), 64'd0);
        bus_rd(A_CTRL, 32'd0, "R1 ctrl readback");
        bus_rd(A_READY, NONE, "R5 none after reset");

        pend_i = '0;
        pend_i[3] = 1'b1; pend_i[7] = 1'b1; pend_i[15] = 1'b1; pend_i[33] = 1'b1;

        bus_wr(A_SETEN, 32'd7);
        bus_wr(A_SETEN, 32'd33);
        idle(1);
        chk("R2 irq gated by ctrl off", 64'(irq_o), 64'd0);

        bus_wr(A_CTRL, 32'd1);
        idle(1);
        chk("R6 irq raised", 64'(irq_o), 64'd1);
        bus_rd(A_CTRL, 32'd1, "R2 ctrl readback");

        bus_rd(A_READY, 32'd7, "R4 lowest first");
        bus_rd(A_READY, 32'd33, "R4 next");
        idle(1);
        chk("R6 irq drops when all in service", 64'(irq_o), 64'd0);
        bus_rd(A_READY, NONE, "R5 none when all in service");

        // R7 completion
        bus_wr(A_DONE, 32'd7);
        chk("R7 clr pulse", 64'(clr_o), 64'd1 << 7);
        idle(1);
        chk("R7 clr one cycle", 64'(clr_o), 64'd0);
        chk("R6 irq back after completion", 64'(irq_o), 64'd1);
        bus_rd(A_READY, 32'd7, "R7 reclaim after completion");

        // R3 disable
        bus_wr(A_CLREN, 32'd33);
        bus_wr(A_DONE, 32'd33);
        bus_rd(A_READY, NONE, "R3 disabled not claimable");
        bus_wr(A_SETEN, 32'd33);
        bus_rd(A_READY, 32'd33, "R3 re-enabled claimable");

        // R9 out-of-range numbers
        bus_wr(A_SETEN, 32'h103);
        bus_wr(A_SETEN, 32'd40);
        bus_rd(A_READY, NONE, "R9 no alias on enable");
        bus_wr(A_DONE, 32'h107);
        chk("R9 no clr on out-of-range done", 64'(clr_o), 64'd0);
        bus_rd(A_READY, NONE, "R9 in-service kept");

        // R4 priority order
        bus_wr(A_SETEN, 32'd15);
        bus_wr(A_SETEN, 32'd3);
        bus_wr(A_DONE, 32'd7);
        bus_rd(A_READY, 32'd3, "R4 order 3");
        bus_rd(A_READY, 32'd7, "R4 order 7");
        bus_rd(A_READY, 32'd15, "R4 order 15");
        bus_rd(A_READY, NONE, "R5 exhausted");

        // R4 pending required
        bus_wr(A_DONE, 32'd15);
        pend_i[15] = 1'b0;
        bus_rd(A_READY, NONE, "R4 not pending not claimable");

        // R6 ctrl off gating
        bus_wr(A_DONE, 32'd3);
        idle(1);
        chk("R6 irq with candidate", 64'(irq_o), 64'd1);
        bus_wr(A_CTRL, 32'd0);
        idle(1);
        chk("R6 irq low with ctrl off", 64'(irq_o), 64'd0);
        bus_rd(A_CTRL, 32'd0, "R2 ctrl cleared");
        bus_rd(A_READY, 32'd3, "R4 claim with ctrl off");

        // R8 send
        bus_wr(A_SEND, 32'h0000_F50E);
        chk("R8 ipi mask", 64'(ipi_o), 64'h5);
        chk("R8 ipi id", 64'(ipi_id_o), 64'hE);
        idle(1);
        chk("R8 ipi one cycle", 64'(ipi_o), 64'd0);
        chk("R8 ipi id cleared", 64'(ipi_id_o), 64'd0);

        // R10 other offsets
        bus_rd(8'h14, 32'd0, "R10 other offset zero");
        bus_rd(A_SEND, 32'd0, "R10 send offset reads zero");

        idle(3);
        chk("R10 all responses seen", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule